// File: doc/BRIEF.md
# General-Purpose Register File with Hardwired Zero

This block is the integer register file of a small 32-bit load/store processor. A three-operand instruction names two source registers and one destination register; the two sources are read through two independent combinational read ports, and the result is written through a single write port on the rising clock edge. Register number 0 is a constant: it reads as zero on every port, and writes addressed to it are dropped. Software can therefore use it as a free zero operand, or as the source of a register-to-register copy.

The widths, the register count and the zero-register option are parameters. A write in the same cycle as a read of the same register does not bypass: the read returns the value held before the edge. A synchronous active-high reset clears every register. A write request whose register number carries unknown bits is discarded.

Top module: `regfile_3p`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared, so after reset every register number reads 0 on both read ports.
- R2: When `wr_en` is high at a rising edge and `wr_idx` is not 0, register `wr_idx` takes `wr_data`, and the new value appears on a read port from the following cycle.
- R3: When `wr_en` is low at a rising edge, no register changes, whatever `wr_idx` and `wr_data` carry.
- R4: A read port whose register number is 0 always returns 0.
- R5: A write addressed to register 0 has no effect: register 0 still reads 0 afterwards and no other register changes.
- R6: A read of the register being written in the same cycle returns the value held before that write.
- R7: The two read ports are independent: each returns the register selected by its own number, including when the two numbers differ.
- R8: A write changes only the addressed register; every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| wr_en | input | 1 | Write request for this cycle |
| wr_idx | input | 5 | Destination register number |
| wr_data | input | 32 | Value to store in the destination register |
| rd_idx_a | input | 5 | Register number for first source operand |
| rd_data_a | output | 32 | Contents of register `rd_idx_a` |
| rd_idx_b | input | 5 | Register number for second source operand |
| rd_data_b | output | 32 | Contents of register `rd_idx_b` |

## Verification
The assertions assume that register numbers and the write enable are fully known (no X or Z bits) at every rising edge, and that reset is held for at least one edge before the first write so that the stored contents start from a defined state. The stimulus drives every input from a defined value at time zero, holds reset for several edges, changes inputs only on the falling edge, and never presents unknown register numbers; the discard path for unknown write numbers is therefore left to the design's own guard rather than to stimulus.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

   // Default geometry of the processor's integer register file
   localparam int unsigned RF_DEF_DATA_W   = 32;
   localparam int unsigned RF_DEF_NUM_REGS = 32;

   // Number of combinational read ports served by the top level
   localparam int unsigned RF_NUM_RD = 2;

   // Register number that may be wired to a constant zero
   localparam int unsigned RF_ZERO_IDX = 0;

   // Lowest register that needs real storage for a given zero option
   function automatic int unsigned rf_first_stored(input bit hard_zero);
      return hard_zero ? RF_ZERO_IDX + 1 : RF_ZERO_IDX;
   endfunction

endpackage

// File: rtl/rf_write_decode.sv
module rf_write_decode #(
   parameter int unsigned NUM_REGS = regfile_pkg::RF_DEF_NUM_REGS,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS),
   parameter int unsigned LO       = 1
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_idx,
   output logic [NUM_REGS-1:LO] wr_sel
);

   logic req_ok;

   // An unknown destination number is never allowed to strobe a register
   always_comb begin
      req_ok = wr_en && !$isunknown(wr_idx);
   end

   for (genvar g = LO; g < NUM_REGS; g++) begin : g_sel
      always_comb begin
         wr_sel[g] = req_ok && (wr_idx == ADDR_W'(g));
      end
   end

endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
   parameter int unsigned DATA_W    = regfile_pkg::RF_DEF_DATA_W,
   parameter int unsigned NUM_REGS  = regfile_pkg::RF_DEF_NUM_REGS,
   parameter bit          HARD_ZERO = 1'b1,
   localparam int unsigned LO       = regfile_pkg::rf_first_stored(HARD_ZERO)
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic [NUM_REGS-1:LO]              wr_sel,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   q
);

   // Constant register: no flops, reads as zero
   if (HARD_ZERO) begin : g_zero
      always_comb begin
         q[regfile_pkg::RF_ZERO_IDX] = '0;
      end
   end

   for (genvar g = LO; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q[g] <= '0;
         end else if (wr_sel[g]) begin
            q[g] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
   parameter int unsigned DATA_W   = regfile_pkg::RF_DEF_DATA_W,
   parameter int unsigned NUM_REGS = regfile_pkg::RF_DEF_NUM_REGS,
   parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] q,
   input  logic [ADDR_W-1:0]               idx,
   output logic [DATA_W-1:0]               data
);

   localparam int unsigned SPAN = 2 ** ADDR_W;

   if (SPAN == NUM_REGS) begin : g_full
      // Every encodable number names a register
      always_comb begin
         data = q[idx];
      end
   end else begin : g_partial
      // Numbers beyond the last register read as zero
      always_comb begin
         data = '0;
         for (int unsigned k = 0; k < NUM_REGS; k++) begin
            if (idx == ADDR_W'(k)) begin
               data = q[k];
            end
         end
      end
   end

endmodule

// File: rtl/regfile_3p.sv
module regfile_3p #(
   parameter int unsigned DATA_W    = regfile_pkg::RF_DEF_DATA_W,
   parameter int unsigned NUM_REGS  = regfile_pkg::RF_DEF_NUM_REGS,
   parameter int unsigned ADDR_W    = $clog2(NUM_REGS),
   parameter bit          HARD_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_idx_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_idx_b,
   output logic [DATA_W-1:0] rd_data_b
);

   localparam int unsigned LO     = regfile_pkg::rf_first_stored(HARD_ZERO);
   localparam int unsigned NUM_RD = regfile_pkg::RF_NUM_RD;

   // Elaboration-time checks on the configuration
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("regfile_3p: NUM_REGS must be at least 2");
   end
   if (DATA_W < 1) begin : g_chk_width
      $error("regfile_3p: DATA_W must be at least 1");
   end
   if ((2 ** ADDR_W) < NUM_REGS) begin : g_chk_addr
      $error("regfile_3p: ADDR_W too narrow for NUM_REGS");
   end

   logic [NUM_REGS-1:LO]            wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] q;
   logic [NUM_RD-1:0][ADDR_W-1:0]   rd_idx;
   logic [NUM_RD-1:0][DATA_W-1:0]   rd_data;

   always_comb begin
      rd_idx[0] = rd_idx_a;
      rd_idx[1] = rd_idx_b;
   end

   rf_write_decode #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .LO       (LO)
   ) u_dec (
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_sel (wr_sel)
   );

   rf_storage #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .HARD_ZERO (HARD_ZERO)
   ) u_store (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .q       (q)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      rf_read_port #(
         .DATA_W   (DATA_W),
         .NUM_REGS (NUM_REGS),
         .ADDR_W   (ADDR_W)
      ) u_rd (
         .q    (q),
         .idx  (rd_idx[p]),
         .data (rd_data[p])
      );
   end

   always_comb begin
      rd_data_a = rd_data[0];
      rd_data_b = rd_data[1];
   end

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter bit          HARD_ZERO = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic [ADDR_W-1:0] rd_idx_a,
   input logic [DATA_W-1:0] rd_data_a,
   input logic [ADDR_W-1:0] rd_idx_b,
   input logic [DATA_W-1:0] rd_data_b
);

   // R1: the first cycle after reset sees only cleared registers
   a_r1_cleared_a: assert property (@(posedge clk)
      $past(rst) && !rst |-> rd_data_a == '0);
   a_r1_cleared_b: assert property (@(posedge clk)
      $past(rst) && !rst |-> rd_data_b == '0);

   // R2: a write reaches the read port one cycle later
   a_r2_write_visible_a: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en) && !$past(rst) && $past(wr_idx) != '0 && rd_idx_a == $past(wr_idx)
      |-> rd_data_a == $past(wr_data));
   a_r2_write_visible_b: assert property (@(posedge clk) disable iff (rst)
      $past(wr_en) && !$past(rst) && $past(wr_idx) != '0 && rd_idx_b == $past(wr_idx)
      |-> rd_data_b == $past(wr_data));

   // R3: with no write request the selected contents hold
   a_r3_idle_hold_a: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) && !$past(rst) && $stable(rd_idx_a) |-> $stable(rd_data_a));
   a_r3_idle_hold_b: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) && !$past(rst) && $stable(rd_idx_b) |-> $stable(rd_data_b));

   // R4 and R5: register 0 reads zero whatever was written to it
   if (HARD_ZERO) begin : g_zero_chk
      a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
         rd_idx_a == '0 |-> rd_data_a == '0);
      a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
         rd_idx_b == '0 |-> rd_data_b == '0);
   end

endmodule

bind regfile_3p rf_checker #(
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .HARD_ZERO (HARD_ZERO)
) u_rf_checker (
   .clk       (clk),
   .rst       (rst),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .wr_data   (wr_data),
   .rd_idx_a  (rd_idx_a),
   .rd_data_a (rd_data_a),
   .rd_idx_b  (rd_idx_b),
   .rd_data_b (rd_data_b)
);

// File: tb/tb_regfile_3p.sv
`timescale 1ns/1ps
module tb_regfile_3p;

   localparam int unsigned DW = 32;
   localparam int unsigned NR = 32;
   localparam int unsigned AW = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] rd_idx_a = '0;
   logic [DW-1:0] rd_data_a;
   logic [AW-1:0] rd_idx_b = '0;
   logic [DW-1:0] rd_data_b;

   logic [DW-1:0] model [NR];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   regfile_3p dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
      .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
   );

   function automatic logic [DW-1:0] pat(input int unsigned i, input logic [DW-1:0] salt);
      return (DW'(i) * 32'h0101_0101) ^ salt ^ (DW'(i) << 27);
   endfunction

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // Both ports swept in opposite orders; compares against the bench model
   task automatic sweep(input string req);
      for (int unsigned i = 0; i < NR; i++) begin
         @(negedge clk);
         rd_idx_a = AW'(i);
         rd_idx_b = AW'(NR - 1 - i);
         #1;
         check(req, rd_data_a, model[i]);
         check(req, rd_data_b, model[NR - 1 - i]);
      end
   endtask

   task automatic wr(input int unsigned idx, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_idx = AW'(idx);
      wr_data = d;
      @(posedge clk);
      if (idx != 0) model[idx] = d;
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      for (int unsigned i = 0; i < NR; i++) model[i] = '0;
   endtask

   initial begin
      for (int unsigned i = 0; i < NR; i++) model[i] = '0;
      do_reset();

      // R1: everything reads zero after reset; R7 opposite port orders
      sweep("R1/R7 after reset");

      // R2, R5: fill every register, register 0 included
      for (int unsigned i = 0; i < NR; i++) wr(i, pat(i, 32'hA5C3_0F1E));
      idle();
      sweep("R2/R4/R5/R7 first fill");

      // R6: same-cycle read of the register under write sees old contents
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF;
      rd_idx_a = 5'd9; rd_idx_b = 5'd9;
      #1;
      check("R6 port a old value", rd_data_a, model[9]);
      check("R6 port b old value", rd_data_b, model[9]);
      @(posedge clk);
      model[9] = 32'hDEAD_BEEF;
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      check("R2 port a new value", rd_data_a, 32'hDEAD_BEEF);
      check("R2 port b new value", rd_data_b, 32'hDEAD_BEEF);

      // R3: idle cycles with live address and data change nothing
      for (int unsigned i = 1; i < NR; i += 3) begin
         @(negedge clk);
         wr_en = 1'b0; wr_idx = AW'(i); wr_data = ~model[i];
      end
      sweep("R3 disabled writes");

      // R8: one write leaves every other register alone
      wr(17, 32'h1234_5678);
      idle();
      sweep("R8 single write");

      // R5: write all ones to register 0
      wr(0, '1);
      idle();
      rd_idx_a = '0; rd_idx_b = '0;
      #1;
      check("R5 zero reg port a", rd_data_a, '0);
      check("R5 zero reg port b", rd_data_b, '0);
      sweep("R5 others intact");

      // Second pattern, back-to-back writes in descending order
      for (int i = NR - 1; i >= 0; i--) wr(i, pat(i, 32'h3C96_E187));
      idle();
      sweep("R2/R8 second fill");

      // R1: reset in mid-run clears a populated file
      do_reset();
      sweep("R1 reset after use");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 50000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule